// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts down a programmed number of seconds and signals when the count runs out. Software writes a seconds value through a small register port, and that value goes straight into a live counter. While the run bit is set, each one-second tick pulse takes one off the counter. When the counter steps from one to zero, the block latches a sticky pending flag and the counter stays at zero.

The pending flag feeds two outputs. The interrupt line is the flag gated by an interrupt-enable bit. The wakeup line is the flag gated by a separate wakeup-enable bit. Software clears the flag by writing one to the status bit. Writing zero to the load register parks the counter at zero before a new count is armed. The reset input is asserted asynchronously, and the block leaves reset two clock edges after the input goes high.

Top module: `sec_alarm`

## Requirements
- R1: After reset, every register reads zero: the load value, the remaining count, the control bits and the pending flag. The interrupt and wakeup outputs are low.
- R2: A write to offset 0x00 copies the write data into the live counter, and the new value reads at offset 0x04 on the next cycle. A read of offset 0x00 returns the last value loaded.
- R3: When control bit 0 (run) at offset 0x08 is set, each cycle with the tick input high takes one off a non-zero remaining count.
- R4: When run is clear, ticks have no effect and the remaining count keeps its value. It is frozen, not cleared.
- R5: A tick that steps the count from 1 to 0 sets the pending flag, which reads as bit 0 of offset 0x0C. After that the count holds at 0 under further ticks.
- R6: Loading zero makes the remaining count read 0 and never sets the pending flag.
- R7: Writing 1 to bit 0 of offset 0x0C clears the pending flag. Writing 0 there leaves the flag as it is.
- R8: If a clear write and an expiry fall in the same cycle, the expiry wins and the flag stays set.
- R9: The interrupt output equals the pending flag AND control bit 1 (interrupt enable).
- R10: The wakeup output equals the pending flag AND control bit 2 (wakeup enable).
- R11: A load write in the same cycle as an enabled tick takes priority, and the counter takes the written value without a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| tick_i | input | 1 | One-second tick pulse, one cycle wide |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The embedded assertions check on every cycle the following behaviours:
- The counter freezes when run is clear and steps down by exactly one on an enabled tick.
- A load takes priority and sets the counter to the written value.
- The counter floors at zero.
- The pending flag rises only after an expiry, and it stays set unless a clear comes with no expiry in the same cycle.

Only the bench scenarios can show how these combine at the register port:
- readback of the stored load value;
- that a zero load never raises pending;
- the gating of the interrupt and wakeup lines by their enables;
- that a clear and an expiry in the same cycle leave pending set.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;
  localparam int unsigned OFF_LOAD   = 32'h00;
  localparam int unsigned OFF_REMAIN = 32'h04;
  localparam int unsigned OFF_CTRL   = 32'h08;
  localparam int unsigned OFF_STATUS = 32'h0C;

  typedef struct packed {
    logic wake_en;
    logic irq_en;
    logic run;
  } alarm_ctl_t;
endpackage

// File: rtl/sec_alarm_rst_sync.sv
module sec_alarm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, step;

  always_comb begin
    step     = run_i && tick_i && !load_i && (cnt_q != '0);
    expire_o = step && (cnt_q == ONE);
    cnt_en   = load_i || step;
    cnt_d    = load_i ? load_val_i : (cnt_q - ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
  assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
  assert_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> cnt_q == '0);
endmodule

// File: rtl/sec_alarm_regs.sv
module sec_alarm_regs
  import sec_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output alarm_ctl_t        ctl_o,
  output logic              pend_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned CTL_W = $bits(alarm_ctl_t);

  logic       sel_load, sel_remain, sel_ctrl, sel_status;
  logic       ctl_we, clr_req;
  logic [CNT_W-1:0] ld_q;
  alarm_ctl_t ctl_q, ctl_d;
  logic       pend_q, pend_d;

  always_comb begin
    sel_load   = (addr_i == ADDR_W'(OFF_LOAD));
    sel_remain = (addr_i == ADDR_W'(OFF_REMAIN));
    sel_ctrl   = (addr_i == ADDR_W'(OFF_CTRL));
    sel_status = (addr_i == ADDR_W'(OFF_STATUS));
    load_o     = we_i && sel_load;
    ctl_we     = we_i && sel_ctrl;
    clr_req    = we_i && sel_status && wdata_i[0];
    ctl_d      = alarm_ctl_t'(wdata_i[CTL_W-1:0]);
    pend_d     = expire_i ? 1'b1 : (clr_req ? 1'b0 : pend_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ld_q <= '0;
    else if (load_o) ld_q <= wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_load)   rdata_o = DATA_W'(ld_q);
    if (sel_remain) rdata_o = DATA_W'(cnt_i);
    if (sel_ctrl)   rdata_o = DATA_W'(ctl_q);
    if (sel_status) rdata_o = DATA_W'(pend_q);
  end

  assign load_val_o = wdata_i[CNT_W-1:0];
  assign ctl_o      = ctl_q;
  assign pend_o     = pend_q;

  assert_set_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(expire_i));
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_req) |=> pend_q);
  assert_expiry_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && clr_req) |=> pend_q);
endmodule

// File: rtl/sec_alarm.sv
module sec_alarm
  import sec_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_i,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned DATA_W = 32;

  logic             rst_n;
  logic             load, expire, pend;
  logic [CNT_W-1:0] load_val, cnt;
  alarm_ctl_t       ctl;

  sec_alarm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  sec_alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .cnt_i(cnt), .expire_i(expire), .load_o(load),
    .load_val_o(load_val), .ctl_o(ctl), .pend_o(pend), .rdata_o(rdata_o)
  );

  sec_alarm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(ctl.run), .tick_i(tick_i),
    .load_i(load), .load_val_i(load_val), .cnt_o(cnt), .expire_o(expire)
  );

  assign irq_o  = pend & ctl.irq_en;
  assign wake_o = pend & ctl.wake_en;
endmodule

// File: tb/sec_alarm_test.sv
module sec_alarm_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        tick;
  logic        irq, wake;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  logic [31:0] m_cnt, m_load;
  logic [2:0]  m_ctl;
  logic        m_pend;

  always #5 clk = ~clk;

  sec_alarm uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .irq_o(irq), .wake_o(wake)
  );

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00:   return m_load;
      8'h04:   return m_cnt;
      8'h08:   return {29'd0, m_ctl};
      8'h0C:   return {31'd0, m_pend};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    logic expire;
    @(posedge clk);
    expire = 1'b0;
    if (!rst_n) begin
      m_cnt = '0; m_load = '0; m_ctl = '0; m_pend = 1'b0;
    end else begin
      if (we && addr == 8'h00) begin
        m_load = wdata; m_cnt = wdata;
      end else if (m_ctl[0] && tick && m_cnt != 0) begin
        if (m_cnt == 1) expire = 1'b1;
        m_cnt = m_cnt - 1;
      end
      if (we && addr == 8'h08) m_ctl = wdata[2:0];
      if (expire) m_pend = 1'b1;
      else if (we && addr == 8'h0C && wdata[0]) m_pend = 1'b0;
    end
    @(negedge clk);
    check(phase, rdata, exp_rd(addr));
    check("R9 irq", {31'd0, irq}, {31'd0, m_pend & m_ctl[1]});
    check("R10 wake", {31'd0, wake}, {31'd0, m_pend & m_ctl[2]});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic t);
    addr = a; wdata = d; we = 1'b1; tick = t;
    cyc();
    we = 1'b0; tick = 1'b0; wdata = '0;
  endtask

  task automatic look(input logic [7:0] a);
    addr = a;
    cyc();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc();
      tick = 1'b0; cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; tick = 1'b0;
    m_cnt = '0; m_load = '0; m_ctl = '0; m_pend = 1'b0;
    repeat (3) cyc();
    @(negedge clk); rst_n = 1'b1;
    phase = "R1";
    repeat (3) cyc();
    look(8'h04); look(8'h08); look(8'h0C); look(8'h00);

    phase = "R2";
    wr(8'h00, 32'd5, 1'b0);
    look(8'h04); look(8'h00);

    phase = "R3";
    wr(8'h08, 32'h1, 1'b0);
    addr = 8'h04;
    ticks(2);
    repeat (3) cyc();

    phase = "R4";
    wr(8'h08, 32'h0, 1'b0);
    addr = 8'h04;
    ticks(3);

    phase = "R5";
    wr(8'h08, 32'h3, 1'b0);
    addr = 8'h04;
    ticks(3);
    look(8'h0C);
    ticks(2);
    look(8'h04);

    phase = "R7";
    wr(8'h0C, 32'h0, 1'b0);
    look(8'h0C);
    wr(8'h0C, 32'h1, 1'b0);
    look(8'h0C);

    phase = "R10";
    wr(8'h08, 32'h5, 1'b0);
    wr(8'h00, 32'd1, 1'b0);
    addr = 8'h0C;
    ticks(1);
    look(8'h0C);

    phase = "R8";
    wr(8'h00, 32'd1, 1'b0);
    wr(8'h0C, 32'h1, 1'b1);
    look(8'h0C); look(8'h04);

    phase = "R6";
    wr(8'h0C, 32'h1, 1'b0);
    wr(8'h08, 32'h7, 1'b0);
    wr(8'h00, 32'd0, 1'b0);
    addr = 8'h04;
    ticks(2);
    look(8'h0C);

    phase = "R11";
    wr(8'h00, 32'd9, 1'b1);
    look(8'h04);
    wr(8'h00, 32'hFFFF_FFFF, 1'b0);
    addr = 8'h04;
    ticks(1);
    wr(8'h00, 32'd4, 1'b1);
    look(8'h04); look(8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule